// File: doc/BRIEF.md
# PHY Register Handshake Master

This block performs reads and writes on 16-bit PHY configuration registers that are not memory-mapped. The PHY is reached through one 20-bit control word, which the block drives, and one 17-bit status word, which the block samples. Each access is split into phases: address capture, data capture, write strobe and read strobe. Each phase is a complete four-phase acknowledge handshake. The block raises a flag in the control word, waits for the acknowledge bit to rise, lowers the flag and waits for the acknowledge bit to fall.

A client starts an access by pulsing `req_valid` while the block is idle. The pulse carries the direction, the PHY register address and, for a write, the data. `busy` stays high until the access ends. The end is marked by a one-cycle `done` pulse. `err` rises with `done` if any acknowledge wait ran out of polls. On a read, the register contents appear on `rdata`. Each acknowledge wait samples the synchronised status at most `MAX_POLLS` times, `POLL_CYCLES` clock cycles apart. By default these are ten polls about one microsecond apart. A wait that never sees the expected level aborts the access and clears the control word.

Top module: `phyhs_master`

## Requirements
- R1: After reset `phy_ctrl` is zero and `busy`, `done` and `err` are low.
- R2: Control word layout: bits 15:0 carry an address or data payload, bit 16 captures the address, bit 17 captures the data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is set at any time. Status word layout: bit 16 is the acknowledge and bits 15:0 carry read data.
- R3: Address capture drives the address alone, then the address with bit 16, and waits for the acknowledge to go high. It then drives the address alone again and waits for the acknowledge to go low.
- R4: After address capture, a write drives the data alone, then the data with bit 17, and waits for ack high. It drives the data alone and waits for ack low. It then drives bit 18 alone and waits for ack high, drives the data alone and waits for ack low. Last, it drives zero and ends with `done` and `err` low.
- R5: After address capture, a read drives bit 19 alone and waits for ack high. At that point it latches status bits 15:0 onto `rdata`. It then drives zero, waits for ack low and ends with `done`; `err` stays low.
- R6: While bit 18 or bit 19 is driven, payload bits 15:0 are zero.
- R7: The status word passes through a two-flop synchroniser. Each acknowledge wait samples it at most `MAX_POLLS` times, `POLL_CYCLES` cycles apart, with the first sample taken on the first cycle of the wait. If the expected level is never seen, the control word returns to zero and `done` and `err` pulse together. If the acknowledge never rises, `done` is seen 2+(MAX_POLLS-1)*POLL_CYCLES cycles after the accepting edge.
- R8: `busy` is high from the cycle after acceptance through the cycle of `done`. `done` lasts exactly one cycle. `err` is high only together with `done`.
- R9: A request presented while `busy` is high has no effect. The control-word sequence of the access in progress is unchanged, and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request pulse, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | Acknowledge timeout, valid with `done` |
| rdata | output | 16 | Data returned by the last read |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY |

## Verification
The bench builds the block with `POLL_CYCLES` = 4 and `MAX_POLLS` = 3. With these values a complete timeout window lasts only ten cycles, so an exact-cycle check of the timeout latency is practical. The bench's PHY responder answers after 0 to 3 cycles. With the two synchroniser stages added, the slowest answer is first seen only at the third and last poll. The full control-word sequences of reads and writes are checked. The bench also holds the acknowledge low in one test and high in another, so both the rising-edge wait and the falling-edge wait run into timeout.

// File: rtl/phyhs_pkg.sv
package phyhs_pkg;
  localparam int PAYLOAD_W    = 16;
  localparam int CTRL_W       = 20;
  localparam int STAT_W       = 17;
  localparam int CAP_ADDR_BIT = 16;
  localparam int CAP_DATA_BIT = 17;
  localparam int WR_STB_BIT   = 18;
  localparam int RD_STB_BIT   = 19;
  localparam int ACK_BIT      = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_SET,
    ST_ADDR_CAP,
    ST_ADDR_REL,
    ST_DATA_SET,
    ST_DATA_CAP,
    ST_DATA_REL,
    ST_WSTB,
    ST_WREL,
    ST_RSTB,
    ST_RREL,
    ST_DONE
  } hs_state_e;
endpackage

// File: rtl/phyhs_sync.sv
module phyhs_sync #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/phyhs_poll.sv
module phyhs_poll #(
  parameter int POLL_CYCLES = 100,
  parameter int MAX_POLLS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  input  logic miss,
  output logic tick,
  output logic last
);
  localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [TW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tmr_d = tmr_q;
    cnt_d = cnt_q;
    if (restart) begin
      tmr_d = '0;
      cnt_d = '0;
    end else if (en) begin
      if (tmr_q == '0) begin
        if (miss) begin
          tmr_d = TW'(POLL_CYCLES - 1);
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      cnt_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      cnt_q <= cnt_d;
    end
  end

  assign tick = en && (tmr_q == '0);
  assign last = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/phyhs_master.sv
module phyhs_master
  import phyhs_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int POLL_CYCLES = CLK_HZ / 1_000_000,
  parameter int MAX_POLLS   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [PAYLOAD_W-1:0] req_addr,
  input  logic [PAYLOAD_W-1:0] req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [PAYLOAD_W-1:0] rdata,
  output logic [CTRL_W-1:0]    phy_ctrl,
  input  logic [STAT_W-1:0]    phy_stat
);
  hs_state_e state_q, state_d;
  logic [PAYLOAD_W-1:0] addr_q, wdat_q, rdata_q;
  logic                 wr_q, err_q, err_d;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic [STAT_W-1:0]    stat_s;
  logic                 ld_req, ld_rd, tick, last, miss, restart, in_wait, ack_ok;

  function automatic logic is_wait(hs_state_e s);
    return (s == ST_ADDR_CAP) || (s == ST_ADDR_REL) || (s == ST_DATA_CAP) ||
           (s == ST_DATA_REL) || (s == ST_WSTB) || (s == ST_WREL) ||
           (s == ST_RSTB) || (s == ST_RREL);
  endfunction

  function automatic logic want_high(hs_state_e s);
    return (s == ST_ADDR_CAP) || (s == ST_DATA_CAP) || (s == ST_WSTB) || (s == ST_RSTB);
  endfunction

  function automatic logic [CTRL_W-1:0] word_of(hs_state_e s, logic [PAYLOAD_W-1:0] a,
                                                logic [PAYLOAD_W-1:0] d);
    logic [CTRL_W-1:0] w;
    w = '0;
    case (s)
      ST_ADDR_SET, ST_ADDR_REL: w[PAYLOAD_W-1:0] = a;
      ST_ADDR_CAP: begin
        w[PAYLOAD_W-1:0] = a;
        w[CAP_ADDR_BIT]  = 1'b1;
      end
      ST_DATA_SET, ST_DATA_REL, ST_WREL: w[PAYLOAD_W-1:0] = d;
      ST_DATA_CAP: begin
        w[PAYLOAD_W-1:0] = d;
        w[CAP_DATA_BIT]  = 1'b1;
      end
      ST_WSTB: w[WR_STB_BIT] = 1'b1;
      ST_RSTB: w[RD_STB_BIT] = 1'b1;
      default: w = '0;
    endcase
    return w;
  endfunction

  phyhs_sync #(.W(STAT_W)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(phy_stat), .q(stat_s)
  );

  phyhs_poll #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) poll_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .en(in_wait), .miss(miss),
    .tick(tick), .last(last)
  );

  assign in_wait = is_wait(state_q);
  assign ack_ok  = (stat_s[ACK_BIT] == want_high(state_q));
  assign ld_req  = (state_q == ST_IDLE) && req_valid;

  // Next state
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    ld_rd   = 1'b0;
    miss    = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = ST_ADDR_SET;
        err_d   = 1'b0;
      end
      ST_ADDR_SET: state_d = ST_ADDR_CAP;
      ST_DATA_SET: state_d = ST_DATA_CAP;
      ST_DONE:     state_d = ST_IDLE;
      default: if (tick) begin
        if (ack_ok) begin
          case (state_q)
            ST_ADDR_CAP: state_d = ST_ADDR_REL;
            ST_ADDR_REL: state_d = wr_q ? ST_DATA_SET : ST_RSTB;
            ST_DATA_CAP: state_d = ST_DATA_REL;
            ST_DATA_REL: state_d = ST_WSTB;
            ST_WSTB:     state_d = ST_WREL;
            ST_RSTB: begin
              state_d = ST_RREL;
              ld_rd   = 1'b1;
            end
            default:     state_d = ST_DONE;
          endcase
        end else if (last) begin
          state_d = ST_DONE;
          err_d   = 1'b1;
        end else begin
          miss = 1'b1;
        end
      end
    endcase
  end

  assign restart = (state_d != state_q) && is_wait(state_d);
  assign ctrl_d  = word_of(state_d, ld_req ? req_addr : addr_q, ld_req ? req_wdata : wdat_q);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
    end else if (ld_req) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
      wr_q   <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (ld_rd) begin
      rdata_q <= stat_s[PAYLOAD_W-1:0];
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign err      = done && err_q;
  assign rdata    = rdata_q;
  assign phy_ctrl = ctrl_q;
endmodule

// File: rtl/phyhs_master_chk.sv
module phyhs_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [19:0] phy_ctrl
);
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[19:16])); // R2

  AST_STROBE_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctrl[18] || phy_ctrl[19]) |-> (phy_ctrl[15:0] == 16'h0)); // R6

  AST_END_CLEARS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phy_ctrl == 20'h0)); // R4

  AST_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (phy_ctrl == 20'h0)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R8

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R8

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phy_ctrl == 20'h0)); // R1
endmodule

bind phyhs_master phyhs_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .done(done), .err(err), .phy_ctrl(phy_ctrl)
);

// File: tb/phyhs_master_tb_top.sv
module phyhs_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS      = 3;
  localparam int PCYC       = 4;
  localparam int TO_LAT     = 2 + (POLLS - 1) * PCYC;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  dly;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 16'h1002, 16'h0000, 2'd0},
    '{1'b1, 16'h1005, 16'h00A5, 2'd0},
    '{1'b0, 16'h1005, 16'h00A5, 2'd1},
    '{1'b1, 16'h100D, 16'h0001, 2'd2},
    '{1'b0, 16'h100D, 16'h0001, 2'd3},
    '{1'b1, 16'h1005, 16'hFFFF, 2'd3},
    '{1'b0, 16'h1005, 16'hFFFF, 2'd2},
    '{1'b0, 16'h100D, 16'h0001, 2'd1}
  };

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata, rdata;
  logic        busy, done, err;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  int checks = 0;
  int fails  = 0;

  phyhs_master #(.POLL_CYCLES(PCYC), .MAX_POLLS(POLLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // PHY responder model
  logic [15:0] regs [16];
  logic [15:0] cap_a, cap_d, rd_out;
  logic        ack_q, mute, stuck;
  int          cnt, dly;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 16'h0;
      cap_a <= 16'h0; cap_d <= 16'h0; rd_out <= 16'h0;
      ack_q <= 1'b0; cnt <= 0;
    end else if (phy_ctrl[19:16] != 4'h0 && !ack_q) begin
      if (mute) cnt <= 0;
      else if (cnt >= dly) begin
        ack_q <= 1'b1; cnt <= 0;
        if (phy_ctrl[16]) cap_a <= phy_ctrl[15:0];
        if (phy_ctrl[17]) cap_d <= phy_ctrl[15:0];
        if (phy_ctrl[18]) regs[cap_a[3:0]] <= cap_d;
        if (phy_ctrl[19]) rd_out <= regs[cap_a[3:0]];
      end else cnt <= cnt + 1;
    end else if (phy_ctrl[19:16] == 4'h0 && ack_q) begin
      if (cnt >= dly) begin ack_q <= 1'b0; cnt <= 0; end
      else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  assign phy_stat = {stuck | ack_q, rd_out};

  // Control-word change log
  logic [19:0] clog [16];
  logic [19:0] last_w;
  int          log_n;
  logic        log_en;

  always @(negedge clk) begin
    if (log_en && phy_ctrl != last_w && log_n < 16) begin
      clog[log_n] = phy_ctrl;
      log_n       = log_n + 1;
      last_w      = phy_ctrl;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_log(input logic [19:0] e [16], input int n, input string req);
    check(log_n == n, req, "sequence length", log_n, n);
    for (int i = 0; i < n && i < log_n; i++)
      check(clog[i] == e[i], req, $sformatf("sequence word %0d", i), clog[i], e[i]);
  endtask

  // Runs one access; lat counts rising edges after the accepting edge.
  task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input int inj, output int lat, output logic e_o,
                        output logic [15:0] rd_o, output logic busy1);
    @(negedge clk);
    log_en = 1'b0; log_n = 0; last_w = 20'h0; log_en = 1'b1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    busy1 = busy;
    while (!done && lat < 3000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == inj) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h1009;
      end else req_valid = 1'b0;
    end
    e_o  = err;
    rd_o = rdata;
    check(done, "R8", "done seen", done, 1);
    check(phy_ctrl == 20'h0, "R4", "word cleared at end", phy_ctrl, 0);
    @(negedge clk);
    check(!done && !busy, "R8", "done one cycle then idle", {done, busy}, 0);
  endtask

  task automatic build_seq(input logic wr, input logic [15:0] a, input logic [15:0] d,
                           output logic [19:0] e [16], output int n);
    for (int i = 0; i < 16; i++) e[i] = 20'h0;
    e[0] = {4'h0, a}; e[1] = {4'h1, a}; e[2] = {4'h0, a};
    if (wr) begin
      e[3] = {4'h0, d}; e[4] = {4'h2, d}; e[5] = {4'h0, d};
      e[6] = {4'h4, 16'h0}; e[7] = {4'h0, d}; e[8] = 20'h0; n = 9;
    end else begin
      e[3] = {4'h8, 16'h0}; e[4] = 20'h0; n = 5;
    end
  endtask

  initial begin
    int lat;
    logic e_o, b1;
    logic [15:0] rd_o;
    logic [19:0] es [16];
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    mute = 1'b0; stuck = 1'b0; dly = 0; log_en = 1'b0; log_n = 0; last_w = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(phy_ctrl == 20'h0, "R1", "reset ctrl", phy_ctrl, 0);
    check(!busy && !done && !err, "R1", "reset flags", {busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(phy_ctrl == 20'h0 && !busy, "R1", "idle after release", {busy, phy_ctrl}, 0);

    // Vector table: R3, R4, R5, R2 field positions
    foreach (VECS[k]) begin
      dly = int'(VECS[k].dly);
      access(VECS[k].wr, VECS[k].addr, VECS[k].data, -1, lat, e_o, rd_o, b1);
      check(b1, "R8", $sformatf("busy after accept v%0d", k), b1, 1);
      check(!e_o, "R7", $sformatf("no timeout v%0d", k), e_o, 0);
      build_seq(VECS[k].wr, VECS[k].addr, VECS[k].data, es, n);
      check_log(es, n, VECS[k].wr ? "R4" : "R5");
      if (!VECS[k].wr)
        check(rd_o == VECS[k].data, "R5", $sformatf("read data v%0d", k), rd_o, VECS[k].data);
    end

    // R9: request while busy is ignored
    dly = 1;
    access(1'b1, 16'h1003, 16'h0033, 3, lat, e_o, rd_o, b1);
    build_seq(1'b1, 16'h1003, 16'h0033, es, n);
    check_log(es, n, "R9");
    begin
      bit extra = 0;
      repeat (30) begin @(negedge clk); if (done || busy) extra = 1; end
      check(!extra, "R9", "no second access", extra, 0);
    end
    access(1'b0, 16'h1003, 16'h0, -1, lat, e_o, rd_o, b1);
    check(rd_o == 16'h0033, "R9", "write unaffected by ignored request", rd_o, 16'h0033);

    // R7: acknowledge never rises
    mute = 1'b1;
    access(1'b1, 16'h1007, 16'h1234, -1, lat, e_o, rd_o, b1);
    check(e_o, "R7", "timeout err (no ack)", e_o, 1);
    check(lat == TO_LAT, "R7", "timeout latency", lat, TO_LAT);
    for (int i = 0; i < 16; i++) es[i] = 20'h0;
    es[0] = {4'h0, 16'h1007}; es[1] = {4'h1, 16'h1007}; es[2] = 20'h0;
    check_log(es, 3, "R7");
    mute = 1'b0;
    repeat (5) @(negedge clk);

    // R7: acknowledge stuck high, falling-edge wait times out
    stuck = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 16'h1006, 16'h0, -1, lat, e_o, rd_o, b1);
    check(e_o, "R7", "timeout err (ack stuck)", e_o, 1);
    check(lat == TO_LAT + 1, "R7", "stuck latency", lat, TO_LAT + 1);
    es[0] = {4'h0, 16'h1006}; es[1] = {4'h1, 16'h1006}; es[2] = {4'h0, 16'h1006};
    es[3] = 20'h0;
    check_log(es, 4, "R3");
    stuck = 1'b0;
    repeat (8) @(negedge clk);

    // Recovery after timeout
    dly = 0;
    access(1'b0, 16'h100D, 16'h0, -1, lat, e_o, rd_o, b1);
    check(!e_o && rd_o == 16'h0001, "R5", "read after timeouts", rd_o, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule